// File: doc/BRIEF.md
# Modem Status Change Detector

This block watches four active-low modem handshake inputs (clear to send, data set ready, ring indicator and carrier detect) and presents them as one 8-bit status word. Each input passes through a synchroniser and is inverted, so it reads as a true-state level. A flag is kept for each line that records a change since the status word was last read.

Three of the lines set their flag on a change in either direction. The ring indicator sets its flag only when it stops being asserted. When host software reads the status word, it raises a read strobe, and that strobe clears the flags. A change that arrives in the same cycle as the read is still recorded. An interrupt request goes out while any flag is set and the modem-status interrupt is enabled.

Top module: `modem_status_detect`

## Requirements
- R1: Bit 0 of `status_o` (clear-to-send change flag) is set when the true state of `line_n_i[0]` changes in either direction.
- R2: Bit 1 of `status_o` (data-set-ready change flag) is set when the true state of `line_n_i[1]` changes in either direction.
- R3: Bit 2 of `status_o` (ring flag) is set only when the true state of `line_n_i[2]` goes from 1 to 0, which is the pin going from 0 to 1. The opposite edge leaves the flag unchanged.
- R4: Bit 3 of `status_o` (carrier change flag) is set when the true state of `line_n_i[3]` changes in either direction.
- R5: Bits 7:4 of `status_o` give the inverse of `line_n_i[3:0]`, with bit 4+i corresponding to line i. After a pin change is first sampled at a clock edge, the new state shows after the next edge, and the matching flag is set one edge later.
- R6: A clock edge with `rd_stb_i` high clears bits 3:0 unless a new change occurs at that edge. Bits 7:4 are not affected by the read.
- R7: A change whose flag would be set at the same edge as a read sets that flag and is not lost.
- R8: `irq_o` is high exactly when `irq_en_i` is high and any of bits 3:0 is set.
- R9: After reset, with all pins high (inactive), `status_o` is 0 and `irq_o` is 0. A set flag holds its value until a read clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_n_i | input | 4 | Raw active-low lines: [0] clear to send, [1] data set ready, [2] ring, [3] carrier |
| rd_stb_i | input | 1 | One-cycle strobe for a read of the status word |
| irq_en_i | input | 1 | Modem-status interrupt enable |
| status_o | output | 8 | Current states [7:4] and change flags [3:0] |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default two-stage synchroniser and four lines. With only four lines there are 16 pin patterns, so it can step through all 256 ordered pairs of a starting pattern and a following pattern. For each pair it compares the flags and the interrupt against values derived from the pin difference, which covers every mix of simultaneous changes and both ring edges. Directed sequences also count the synchroniser latency cycle by cycle, place a read on the exact edge where a flag gets set, and check that flags stay set over long idle stretches.

// File: rtl/msd_pkg.sv
package msd_pkg;
  localparam int unsigned NUM_LINES = 4;
  localparam int unsigned IDX_CTS   = 0;
  localparam int unsigned IDX_DSR   = 1;
  localparam int unsigned IDX_RING  = 2;
  localparam int unsigned IDX_DCD   = 3;

  // Event for one line: any change, or only the 1->0 move of the true state.
  function automatic logic line_event(input logic cur, input logic prev,
                                      input logic fall_only);
    if (fall_only) return prev & ~cur;
    return cur ^ prev;
  endfunction

  // Flag update: a read clears the flags, and new events are then ORed back in.
  function automatic logic [NUM_LINES-1:0] flag_next(
      input logic [NUM_LINES-1:0] flags, input logic [NUM_LINES-1:0] evts,
      input logic rd);
    return (rd ? '0 : flags) | evts;
  endfunction
endpackage

// File: rtl/msd_sync.sv
module msd_sync #(
  parameter int unsigned WIDTH   = 4,
  parameter int unsigned STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/msd_edge.sv
module msd_edge
  import msd_pkg::*;
#(
  parameter bit FALL_ONLY = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic evt_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= level_i;
  end

  assign evt_o = line_event(level_i, prev_q, FALL_ONLY);
endmodule

// File: rtl/msd_flags.sv
module msd_flags
  import msd_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] evt_i,
  input  logic                 rd_i,
  output logic [NUM_LINES-1:0] flags_o
);
  logic [NUM_LINES-1:0] flags_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flag_next(flags_q, evt_i, rd_i);
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/modem_status_detect.sv
module modem_status_detect
  import msd_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] line_n_i,
  input  logic       rd_stb_i,
  input  logic       irq_en_i,
  output logic [7:0] status_o,
  output logic       irq_o
);
  logic [NUM_LINES-1:0] pin_sync;
  logic [NUM_LINES-1:0] state_true;
  logic [NUM_LINES-1:0] line_evt;
  logic [NUM_LINES-1:0] flags;

  msd_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(line_n_i), .q_o(pin_sync)
  );

  assign state_true = ~pin_sync;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    msd_edge #(.FALL_ONLY(i == IDX_RING)) u_edge (
      .clk(clk), .rst_n(rst_n), .level_i(state_true[i]), .evt_o(line_evt[i])
    );
  end

  msd_flags u_flags (
    .clk(clk), .rst_n(rst_n), .evt_i(line_evt), .rd_i(rd_stb_i), .flags_o(flags)
  );

  assign status_o = {state_true, flags};
  assign irq_o    = irq_en_i & (|flags);

  assert_cts_flag_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[4] != $past(status_o[4])) |=> status_o[0]);
  assert_dsr_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[5] != $past(status_o[5])) |=> status_o[1]);
  assert_ring_trail_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status_o[6]) |=> status_o[2]);
  assert_ring_no_lead_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(status_o[6]) && !status_o[2]) |=> !status_o[2]);
  assert_dcd_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[7] != $past(status_o[7])) |=> status_o[3]);
  assert_read_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb_i && $stable(status_o[7:4])) |=> (status_o[3:0] == 4'h0));
  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb_i |=> ((status_o[3:0] & $past(status_o[3:0])) == $past(status_o[3:0])));
  assert_irq_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en_i |-> !irq_o);
  assert_irq_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en_i && status_o[3:0] != 4'h0) |-> irq_o);
endmodule

// File: tb/test_modem_status_detect.sv
module test_modem_status_detect;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] line_n_i = 4'hF;
  logic       rd_stb_i = 1'b0;
  logic       irq_en_i = 1'b0;
  logic [7:0] status_o;
  logic       irq_o;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  modem_status_detect i_modem_status_detect (
    .clk(clk), .rst_n(rst_n), .line_n_i(line_n_i), .rd_stb_i(rd_stb_i),
    .irq_en_i(irq_en_i), .status_o(status_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Flags expected for a move of the pins from p to q.
  function automatic logic [3:0] exp_flags(input logic [3:0] p, input logic [3:0] q);
    logic [3:0] d = p ^ q;
    return {d[3], (~p[2] & q[2]), d[1], d[0]};
  endfunction

  task automatic do_read();
    @(negedge clk) rd_stb_i = 1'b1;
    @(negedge clk) rd_stb_i = 1'b0;
  endtask

  task automatic drive_settle(input logic [3:0] v);
    @(negedge clk) line_n_i = v;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 reset", {irq_o, status_o}, 9'h000);

    // Exhaustive pairs of pin patterns
    for (int p = 0; p < 16; p++) begin
      for (int q = 0; q < 16; q++) begin
        logic [3:0] ef;
        drive_settle(4'(p));
        do_read();
        irq_en_i = 1'(p[0] ^ q[1]);
        drive_settle(4'(q));
        ef = exp_flags(4'(p), 4'(q));
        chk("R1 R2 R3 R4 R5 flags/state", {1'b0, status_o}, {1'b0, ~4'(q), ef});
        chk("R8 irq", {8'h0, irq_o}, {8'h0, irq_en_i & (|ef)});
        do_read();
        chk("R6 read clears", {1'b0, status_o}, {1'b0, ~4'(q), 4'h0});
      end
    end
    irq_en_i = 1'b1;
    drive_settle(4'hF);
    do_read();

    // Latency of state and flag, carrier line
    @(negedge clk) line_n_i = 4'h7;
    @(posedge clk); @(negedge clk);
    chk("R5 latency edge1", {1'b0, status_o}, 9'h000);
    @(posedge clk); @(negedge clk);
    chk("R5 latency edge2", {1'b0, status_o}, 9'h080);
    @(posedge clk); @(negedge clk);
    chk("R4 flag at edge3", {irq_o, status_o}, 9'h188);

    // Sticky hold
    repeat (20) @(negedge clk);
    chk("R9 sticky", {irq_o, status_o}, 9'h188);
    do_read();
    chk("R6 cleared", {irq_o, status_o}, 9'h080);

    // Read on the same edge as a new flag
    @(negedge clk) line_n_i = 4'h6;
    @(posedge clk); @(posedge clk);
    @(negedge clk) rd_stb_i = 1'b1;
    @(posedge clk);
    @(negedge clk) rd_stb_i = 1'b0;
    chk("R7 change during read", {irq_o, status_o}, 9'h191);
    do_read();
    chk("R7 then cleared", {1'b0, status_o}, 9'h090);

    // Ring lead then trail
    drive_settle(4'h2);
    chk("R3 lead no flag", {1'b0, status_o}, 9'h0D0);
    drive_settle(4'h6);
    chk("R3 trail flag", {1'b0, status_o}, 9'h094);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule